// File: doc/BRIEF.md
# I2C Bit-Clock Prescaler

This block turns a fast system clock into the timing strobes that pace an I2C master's bit engine. A 7-bit divider word holds two fields: a linear factor M and a power-of-two factor N. A linear counter runs from 0 to M. Each time it wraps, a free-running binary counter steps. A phase tick is issued once every 2^(N+1) such steps. One SCL bit lasts ten phase ticks, so the SCL rate is f_sys / (10 × (M+1) × 2^(N+1)).

A ten-step phase sequencer follows the ticks. It tells the bit engine when to hold SCL low, when to release it, when to change SDA and when to sample it. A divider write is held back until the current bit ends, so the block never produces a shortened SCL pulse. Dropping the enable holds every counter cleared. A soft-reset pulse clears the counters and also the divider word, so software must write the divider again after a soft reset. There is no streaming data path. Every pin is a plain control or timing signal.

Top module: `i2c_bitclk_prescaler`

## Requirements
- R1: While enabled, consecutive tick_o pulses are exactly P = (M+1) × 2^(N+1) cycles apart. The cycle in which enable_i is first seen high counts as cycle 0, and the first tick_o appears in cycle P−1.
- R2: The divider word is decoded as N = cfg_wdata_i[2:0] (0 to 7) and M = cfg_wdata_i[6:3] (0 to 15).
- R3: phase_o starts at 0. It advances by one in the cycle after each tick_o and wraps from 9 back to 0. bit_end_o is high exactly in a tick_o cycle with phase_o = 9.
- R4: scl_low_o is high when enabled, not in soft reset, and phase_o is 0 to 4. It is low in phases 5 to 9 and whenever the block is disabled.
- R5: sda_upd_o is high exactly in the tick_o cycle that moves phase_o from 1 to 2. sda_smp_o is high exactly in the tick_o cycle that moves phase_o from 6 to 7.
- R6: A divider write made while enabled does not change the bit in progress. The new P applies from the tick after the next bit_end_o, and that first tick comes a full new P after the bit_end_o tick. A write made while disabled takes effect within two cycles.
- R7: While enable_i is low, no tick_o or strobe is produced and phase_o reads 0.
- R8: A soft_rst_i cycle clears the counters and phase_o, and sets the divider to M=0, N=0. A divider write in the same cycle is discarded.
- R9: After rst_ni is released with enable_i low, all outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Controller enable; low holds the counters cleared |
| soft_rst_i | input | 1 | Synchronous soft reset of the counters and the divider word |
| cfg_we_i | input | 1 | Divider word write strobe |
| cfg_wdata_i | input | 7 | Divider word: M in [6:3], N in [2:0] |
| tick_o | output | 1 | Phase tick, ten per SCL bit |
| phase_o | output | 4 | Current phase, 0 to 9 |
| scl_low_o | output | 1 | Drive SCL low in this phase |
| sda_upd_o | output | 1 | Strobe for changing SDA (entering phase 2) |
| sda_smp_o | output | 1 | Strobe for sampling SDA (entering phase 7) |
| bit_end_o | output | 1 | Last tick of a bit period |

## Verification
The properties assume that enable_i, soft_rst_i and the divider write are synchronous to clk_i and are not touched during reset. They also assume the period is at least two cycles, which holds for every legal divider word. The stimulus changes every input only at the falling edge. It never writes the divider in the same cycle as a bit_end_o tick, so each boundary it checks applies a known value. Tick spacing and phase order are checked by counting cycles at the ports, for divider words whose M and N fields are distinct enough that a swapped or misplaced field gives a different period.

// File: rtl/i2cpre_pkg.sv
package i2cpre_pkg;
  localparam int M_W        = 4;
  localparam int N_W        = 3;
  localparam int CFG_W      = M_W + N_W;
  localparam int NUM_PHASES = 10;
  localparam int PH_W       = $clog2(NUM_PHASES);
  localparam int LOW_PHASES = 5;
  localparam int UPD_PHASE  = 2;
  localparam int SMP_PHASE  = 7;

  // Field layout: M in the upper bits, N in the lower bits.
  typedef struct packed {
    logic [M_W-1:0] lin;
    logic [N_W-1:0] pow;
  } div_word_t;
endpackage

// File: rtl/i2cpre_cfg_hold.sv
module i2cpre_cfg_hold
  import i2cpre_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             enable_i,
  input  logic             wr_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic             boundary_i,
  output div_word_t        active_o
);
  div_word_t pend_q, act_q;

  // Pending word takes every write; active word follows only at a bit
  // boundary or while the counters are idle.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      act_q  <= '0;
    end else if (soft_rst_i) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      if (wr_i) pend_q <= div_word_t'(wdata_i);
      if (!enable_i || boundary_i) act_q <= pend_q;
    end
  end

  assign active_o = act_q;
endmodule

// File: rtl/i2cpre_lin_stage.sv
module i2cpre_lin_stage #(
  parameter int M_W = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic [M_W-1:0] lim_i,
  output logic           wrap_o
);
  logic [M_W-1:0] cnt_q;

  assign wrap_o = run_i && (cnt_q == lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (wrap_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/i2cpre_bin_stage.sv
module i2cpre_bin_stage #(
  parameter int N_W   = 3,
  localparam int BIN_W = 1 << N_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic           step_i,
  input  logic           restart_i,
  input  logic [N_W-1:0] pow_i,
  output logic           tick_o
);
  logic [BIN_W-1:0] cnt_q;
  logic [BIN_W-1:0] low_mask;

  // Bits 0..N form the window whose all-ones state ends a tick period.
  for (genvar i = 0; i < BIN_W; i++) begin : g_mask
    assign low_mask[i] = (N_W'(i) <= pow_i);
  end

  assign tick_o = step_i && ((cnt_q | ~low_mask) == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!run_i)    cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (step_i)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/i2cpre_phase_seq.sv
module i2cpre_phase_seq #(
  parameter int NUM_PHASES = 10,
  parameter int LOW_PHASES = 5,
  parameter int UPD_PHASE  = 2,
  parameter int SMP_PHASE  = 7,
  localparam int PH_W      = $clog2(NUM_PHASES)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            tick_i,
  output logic [PH_W-1:0] phase_o,
  output logic            scl_low_o,
  output logic            upd_o,
  output logic            smp_o,
  output logic            last_o
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(NUM_PHASES - 1);
  localparam logic [PH_W-1:0] PRE_UPD = PH_W'(UPD_PHASE - 1);
  localparam logic [PH_W-1:0] PRE_SMP = PH_W'(SMP_PHASE - 1);
  localparam logic [PH_W-1:0] LOW_END = PH_W'(LOW_PHASES);

  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ph_q <= '0;
    else if (!run_i)      ph_q <= '0;
    else if (tick_i) begin
      if (ph_q == LAST_PH) ph_q <= '0;
      else                 ph_q <= ph_q + 1'b1;
    end
  end

  assign phase_o   = ph_q;
  assign scl_low_o = run_i && (ph_q < LOW_END);
  assign upd_o     = tick_i && (ph_q == PRE_UPD);
  assign smp_o     = tick_i && (ph_q == PRE_SMP);
  assign last_o    = tick_i && (ph_q == LAST_PH);
endmodule

// File: rtl/i2c_bitclk_prescaler.sv
module i2c_bitclk_prescaler
  import i2cpre_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             soft_rst_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic             tick_o,
  output logic [PH_W-1:0]  phase_o,
  output logic             scl_low_o,
  output logic             sda_upd_o,
  output logic             sda_smp_o,
  output logic             bit_end_o
);
  logic      run;
  logic      lin_wrap;
  logic      tick;
  logic      bit_end;
  div_word_t div_act;

  assign run = enable_i && !soft_rst_i;

  i2cpre_cfg_hold u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst_i),
    .enable_i   (enable_i),
    .wr_i       (cfg_we_i),
    .wdata_i    (cfg_wdata_i),
    .boundary_i (bit_end),
    .active_o   (div_act)
  );

  i2cpre_lin_stage #(.M_W(M_W)) u_lin (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .lim_i  (div_act.lin),
    .wrap_o (lin_wrap)
  );

  i2cpre_bin_stage #(.N_W(N_W)) u_bin (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .step_i    (lin_wrap),
    .restart_i (bit_end),
    .pow_i     (div_act.pow),
    .tick_o    (tick)
  );

  i2cpre_phase_seq #(
    .NUM_PHASES (NUM_PHASES),
    .LOW_PHASES (LOW_PHASES),
    .UPD_PHASE  (UPD_PHASE),
    .SMP_PHASE  (SMP_PHASE)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .tick_i    (tick),
    .phase_o   (phase_o),
    .scl_low_o (scl_low_o),
    .upd_o     (sda_upd_o),
    .smp_o     (sda_smp_o),
    .last_o    (bit_end)
  );

  assign tick_o    = tick;
  assign bit_end_o = bit_end;
endmodule

// File: rtl/i2cpre_checker.sv
module i2cpre_checker
  import i2cpre_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            enable_i,
  input logic            soft_rst_i,
  input logic            tick_o,
  input logic [PH_W-1:0] phase_o,
  input logic            sda_upd_o,
  input logic            sda_smp_o,
  input logic            bit_end_o
);
  p_phase_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o < PH_W'(NUM_PHASES));

  p_phase_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (phase_o == (($past(phase_o) == PH_W'(NUM_PHASES - 1)) ? '0 : $past(phase_o) + 1'b1)));

  p_phase_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_o && enable_i && !soft_rst_i) |=> $stable(phase_o));

  p_bit_end_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_end_o |=> (phase_o == '0));

  p_upd_point_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_upd_o |=> (phase_o == PH_W'(UPD_PHASE)));

  p_smp_point_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_smp_o |=> (phase_o == PH_W'(SMP_PHASE)));

  p_idle_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (phase_o == '0));

  p_soft_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (phase_o == '0));

  p_tick_gap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

bind i2c_bitclk_prescaler i2cpre_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .enable_i   (enable_i),
  .soft_rst_i (soft_rst_i),
  .tick_o     (tick_o),
  .phase_o    (phase_o),
  .sda_upd_o  (sda_upd_o),
  .sda_smp_o  (sda_smp_o),
  .bit_end_o  (bit_end_o)
);

// File: tb/i2c_bitclk_prescaler_tb_top.sv
`timescale 1ns/1ps
module i2c_bitclk_prescaler_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       enable_i = 1'b0;
  logic       soft_rst_i = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [6:0] cfg_wdata_i = '0;
  logic       tick_o, scl_low_o, sda_upd_o, sda_smp_o, bit_end_o;
  logic [3:0] phase_o;

  int checks = 0;
  int fails  = 0;
  localparam int LIM = 5000;

  always #2.5 clk_i = ~clk_i;

  i2c_bitclk_prescaler dut_i (.*);

  // Vector table: M, N, expected period (M+1)*2^(N+1).
  localparam int NV = 7;
  localparam int VM [NV] = '{0, 3, 15, 2, 0, 1, 5};
  localparam int VN [NV] = '{0, 1, 0,  2, 3, 5, 7};
  localparam int VP [NV] = '{2, 16, 32, 24, 16, 128, 1536};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Advance to the next cycle with tick_o high; n = cycles advanced.
  task automatic next_tick(output int n);
    n = 0;
    do begin
      @(negedge clk_i);
      cfg_we_i = 1'b0;
      #1;
      n++;
    end while (!tick_o && n < LIM);
  endtask

  task automatic write_cfg(input int m, input int n);
    @(negedge clk_i);
    cfg_we_i = 1'b1;
    cfg_wdata_i = {4'(m), 3'(n)};
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  // Enable at a falling edge; n = index of the first tick cycle.
  task automatic enable_and_latency(output int n);
    @(negedge clk_i);
    enable_i = 1'b1;
    #1;
    n = 0;
    while (!tick_o && n < LIM) begin
      @(negedge clk_i);
      #1;
      n++;
    end
  endtask

  initial begin
    #(5.0 * 190000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n;
    int ph;
    bool_dummy();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #1;
    // R9 reset state
    check(phase_o == 0, "R9 phase", phase_o, 0);
    check({tick_o, scl_low_o, sda_upd_o, sda_smp_o, bit_end_o} == 5'b0, "R9 outputs",
          {tick_o, scl_low_o, sda_upd_o, sda_smp_o, bit_end_o}, 0);

    // R1/R2 table walk
    for (int v = 0; v < NV; v++) begin
      @(negedge clk_i);
      enable_i = 1'b0;
      write_cfg(VM[v], VN[v]);
      repeat (3) @(negedge clk_i);
      enable_and_latency(n);
      check(n == VP[v] - 1, "R1 R2 first tick", n, VP[v] - 1);
      for (int k = 0; k < 2; k++) begin
        next_tick(n);
        check(n == VP[v], "R1 R2 period", n, VP[v]);
      end
    end

    // R3/R4/R5 phase walk with P=2
    @(negedge clk_i);
    enable_i = 1'b0;
    write_cfg(0, 0);
    repeat (3) @(negedge clk_i);
    @(negedge clk_i);
    enable_i = 1'b1;
    #1;
    check(phase_o == 0 && scl_low_o, "R3 R4 start phase", {phase_o, scl_low_o}, 1);
    for (int k = 0; k < 20; k++) begin
      next_tick(n);
      ph = k % 10;
      check(phase_o == ph, "R3 phase", phase_o, ph);
      check(scl_low_o == (ph < 5), "R4 scl_low", scl_low_o, ph < 5);
      check(sda_upd_o == (ph == 1), "R5 upd", sda_upd_o, ph == 1);
      check(sda_smp_o == (ph == 6), "R5 smp", sda_smp_o, ph == 6);
      check(bit_end_o == (ph == 9), "R3 bit_end", bit_end_o, ph == 9);
    end
    @(negedge clk_i);
    #1;
    check(phase_o == 0, "R3 wrap", phase_o, 0);

    // R6 write mid-bit: seek the tick at phase 2, then write M=1,N=0 (P=4)
    do next_tick(n); while (phase_o != 2);
    cfg_we_i = 1'b1;
    cfg_wdata_i = {4'd1, 3'd0};
    for (int k = 0; k < 7; k++) begin
      next_tick(n);
      check(n == 2, "R6 old period kept", n, 2);
    end
    check(bit_end_o == 1'b1, "R6 boundary", bit_end_o, 1);
    for (int k = 0; k < 2; k++) begin
      next_tick(n);
      check(n == 4, "R6 new period", n, 4);
    end

    // R8 soft reset with a write in the same cycle
    @(negedge clk_i);
    enable_i = 1'b0;
    write_cfg(3, 1);
    repeat (3) @(negedge clk_i);
    enable_and_latency(n);
    next_tick(n);
    next_tick(n);
    check(phase_o == 2, "R8 pre phase", phase_o, 2);
    @(negedge clk_i);
    soft_rst_i = 1'b1;
    cfg_we_i = 1'b1;
    cfg_wdata_i = {4'd7, 3'd2};
    @(negedge clk_i);
    soft_rst_i = 1'b0;
    cfg_we_i = 1'b0;
    #1;
    check(phase_o == 0, "R8 phase cleared", phase_o, 0);
    n = 0;
    while (!tick_o && n < LIM) begin
      @(negedge clk_i);
      #1;
      n++;
    end
    check(n == 1, "R8 divider cleared latency", n, 1);
    next_tick(n);
    check(n == 2, "R8 divider cleared period", n, 2);

    // R7 disable mid-bit
    next_tick(n);
    next_tick(n);
    @(negedge clk_i);
    enable_i = 1'b0;
    begin
      int bad = 0;
      for (int c = 0; c < 40; c++) begin
        @(negedge clk_i);
        #1;
        if (tick_o || sda_upd_o || sda_smp_o || bit_end_o || scl_low_o || phase_o != 0) bad++;
      end
      check(bad == 0, "R7 idle while disabled", bad, 0);
    end
    enable_and_latency(n);
    check(n == 1, "R7 restart from cleared", n, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  task automatic bool_dummy();
  endtask
endmodule